// File: doc/BRIEF.md
# Block-Transfer Configuration Slave for a Two-Wire Bus

This block is a byte-oriented slave on a two-wire serial bus. It holds six 8-bit configuration registers and presents them as one parallel vector to the clock-distribution logic next to it. A system clock oversamples SCL and SDA. The block finds start and stop conditions, recognises one fixed address byte for writes and one for reads, and acknowledges bytes by pulling SDA low through an open-drain enable. The bus runs in standard mode, at 100 kbit/s or slower.

Only block transfers are supported. A write carries two leading bytes, a command and a count. Both are acknowledged and then discarded. The data bytes that follow fill the registers from index 0 upward, and the host may stop after any whole byte. A read first returns a byte count and then the registers from index 0 upward. It ends when the host answers a byte with not-acknowledge.

Top module: `cfg_blk_slave`

## Requirements
- R1: After reset, register 0 (`cfg_o[7:0]`) is 0x00 and registers 1 to 5 (`cfg_o[8k+7:8k]` for register k) are 0xFF. `sda_oe` is low.
- R2: The address bytes 0xD4 (write) and 0xD5 (read) are acknowledged: SDA is held low during the ninth SCL pulse. Any other address gets no acknowledge, and SDA stays released until the next start.
- R3: In a write, the first two bytes after the address are acknowledged and leave every register unchanged.
- R4: In a write, the data bytes after those two go to registers 0, 1, 2 and so on in ascending order. Each one is acknowledged and appears on `cfg_o`.
- R5: A stop after any whole data byte leaves the registers already written with their new values. All other registers keep their old values.
- R6: Write data bytes beyond register 5 are acknowledged and discarded.
- R7: A read sends the byte count 6 and then registers 0 to 5, each byte most significant bit first. SDA drive changes only while SCL is low.
- R8: Read bytes requested beyond register 5 return 0xFF.
- R9: When the host answers a read byte with not-acknowledge, the slave releases SDA and drives nothing until the next start or stop.
- R10: A start in the middle of a transfer discards the partial byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_o | output | 48 | Register k on bits [8k+7:8k] |

## Verification
A table of write transactions is applied. The entries differ in address, in the number of data bytes (zero, one, two, exactly six and eight) and in data pattern. Each write is followed by a full read-back that runs one byte past the last register.

The short writes show that untouched registers hold their values. The long write shows that extra bytes are discarded. The zero-length write shows that the command and count bytes are not stored. The foreign address must leave the registers unchanged and draw no acknowledge.

Directed cases cover the reset values, an early not-acknowledge from the host during a read, and a start that cuts a data byte off after three bits.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int          SBC_NUM_REGS = 6;
  localparam logic [7:0]  SBC_WR_ADDR  = 8'hD4;
  localparam logic [7:0]  SBC_RD_ADDR  = 8'hD5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE,
    ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK, ST_WAIT_STOP
  } sbc_state_e;

  function automatic logic [7:0] sbc_reset_value(input int idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction
endpackage

// File: rtl/sbc_sync.sv
module sbc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  // [0] first flop, [1] synchronized, [2] previous synchronized
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign scl_rise = scl_q[1] & ~scl_q[2];
  assign scl_fall = ~scl_q[1] & scl_q[2];
  assign start_p  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_p   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/sbc_engine.sv
module sbc_engine
  import sbc_pkg::*;
#(
  parameter int NUM_REGS = SBC_NUM_REGS,
  parameter int IDX_W    = $clog2(NUM_REGS + 3)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_s,
  input  logic                  sda_s,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_p,
  input  logic                  stop_p,
  input  logic [NUM_REGS*8-1:0] rd_data,
  output logic                  sda_oe,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [7:0]            wr_data
);
  localparam int IDX_MAX = NUM_REGS + 2;

  sbc_state_e       state, state_d;
  logic [2:0]       bit_cnt, bit_cnt_d;
  logic             byte_done, byte_done_d;
  logic             is_rd, is_rd_d;
  logic [7:0]       shreg, shreg_d;
  logic [IDX_W-1:0] byte_idx, byte_idx_d, idx_inc;
  logic             oe_d;
  logic [7:0]       rd_byte;

  // byte to send for the current read position: count, registers, then filler
  always_comb begin
    rd_byte = 8'hFF;
    if (byte_idx == '0) rd_byte = 8'(NUM_REGS);
    for (int k = 0; k < NUM_REGS; k++)
      if (int'(byte_idx) == k + 1) rd_byte = rd_data[k*8 +: 8];
  end

  assign idx_inc = (int'(byte_idx) == IDX_MAX) ? byte_idx : byte_idx + IDX_W'(1);
  assign wr_idx  = byte_idx - IDX_W'(2);
  assign wr_data = shreg;

  always_comb begin
    state_d     = state;
    bit_cnt_d   = bit_cnt;
    byte_done_d = byte_done;
    is_rd_d     = is_rd;
    shreg_d     = shreg;
    byte_idx_d  = byte_idx;
    oe_d        = sda_oe;
    wr_en       = 1'b0;
    if (start_p) begin
      state_d     = ST_ADDR;
      bit_cnt_d   = '0;
      byte_done_d = 1'b0;
      oe_d        = 1'b0;
    end else if (stop_p) begin
      state_d     = ST_IDLE;
      byte_done_d = 1'b0;
      oe_d        = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise) begin
            shreg_d   = {shreg[6:0], sda_s};
            bit_cnt_d = bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_done_d = 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done_d = 1'b0;
            if (state == ST_ADDR) begin
              byte_idx_d = '0;
              if (shreg == SBC_WR_ADDR || shreg == SBC_RD_ADDR) begin
                state_d = ST_ADDR_ACK;
                is_rd_d = shreg[0];
                oe_d    = 1'b1;
              end else begin
                state_d = ST_WAIT_STOP;
              end
            end else begin
              wr_en      = (int'(byte_idx) >= 2) && (int'(byte_idx) < IDX_MAX);
              byte_idx_d = idx_inc;
              state_d    = ST_WR_ACK;
              oe_d       = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          bit_cnt_d = '0;
          if (is_rd) begin
            state_d    = ST_RD_BYTE;
            shreg_d    = rd_byte;
            oe_d       = ~rd_byte[7];
            byte_idx_d = idx_inc;
          end else begin
            state_d = ST_WR_BYTE;
            oe_d    = 1'b0;
          end
        end
        ST_WR_ACK: if (scl_fall) begin
          state_d = ST_WR_BYTE;
          oe_d    = 1'b0;
        end
        ST_RD_BYTE: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            state_d   = ST_RD_ACK;
            bit_cnt_d = '0;
            oe_d      = 1'b0;
          end else begin
            shreg_d   = {shreg[6:0], 1'b0};
            oe_d      = ~shreg[6];
            bit_cnt_d = bit_cnt + 3'd1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise && sda_s) begin
            state_d = ST_WAIT_STOP;
          end else if (scl_fall) begin
            state_d    = ST_RD_BYTE;
            shreg_d    = rd_byte;
            oe_d       = ~rd_byte[7];
            byte_idx_d = idx_inc;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      is_rd     <= 1'b0;
      shreg     <= '0;
      byte_idx  <= '0;
      sda_oe    <= 1'b0;
    end else begin
      state     <= state_d;
      bit_cnt   <= bit_cnt_d;
      byte_done <= byte_done_d;
      is_rd     <= is_rd_d;
      shreg     <= shreg_d;
      byte_idx  <= byte_idx_d;
      sda_oe    <= oe_d;
    end
  end

  // R7: the slave starts pulling SDA only while SCL is low
  p_drive_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);
  // R2: acknowledge phases of the slave always pull SDA
  p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> sda_oe);
  // R9: after a refused byte or a foreign address SDA is released
  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_STOP) |-> !sda_oe);
  // R10: a start restarts address reception from bit zero
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (state == ST_ADDR && bit_cnt == 3'd0 && !sda_oe));
endmodule

// File: rtl/sbc_regs.sv
module sbc_regs
  import sbc_pkg::*;
#(
  parameter int NUM_REGS = SBC_NUM_REGS,
  parameter int IDX_W    = $clog2(NUM_REGS + 3)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    logic       en;
    assign en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= sbc_reset_value(g);
      else if (en) q <= wr_data;
    end
    assign regs_o[g*8 +: 8] = q;
  end

  // R5: without a write strobe every register holds its value
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));
endmodule

// File: rtl/cfg_blk_slave.sv
module cfg_blk_slave
  import sbc_pkg::*;
#(
  parameter int NUM_REGS = SBC_NUM_REGS,
  localparam int IDX_W   = $clog2(NUM_REGS + 3)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic [1:0]       rst_q;
  logic             rst_s_n;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  sbc_sync u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  sbc_engine #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_s_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .rd_data(cfg_o), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data)
  );

  sbc_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(cfg_o)
  );
endmodule

// File: tb/tb_cfg_blk_slave.sv
module tb_cfg_blk_slave;
  localparam int Q = 10;  // quarter of an SCL period, in clk cycles
  localparam int NV = 6;
  // {address byte, data byte count, data seed}
  localparam logic [19:0] VEC [NV] = '{
    {8'hD4, 4'd6, 8'h11},
    {8'hD4, 4'd2, 8'hA0},
    {8'hD4, 4'd8, 8'h3C},
    {8'hA4, 4'd3, 8'h55},
    {8'hD4, 4'd0, 8'h00},
    {8'hD4, 4'd1, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1, sda_m = 1'b1;
  logic        sda_oe;
  logic [47:0] cfg_o;
  logic        sda_line;
  logic [7:0]  mdl [6];
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  cfg_blk_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                     .sda_oe(sda_oe), .cfg_o(cfg_o));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q); seen = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~host_ack, s);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 29);
  endfunction

  task automatic do_write(input logic [7:0] addr, input int n, input logic [7:0] seed);
    logic a;
    bus_start();
    send_byte(addr, a);
    chk("R2 address acknowledge", {7'd0, a}, {7'd0, addr == 8'hD4});
    if (a) begin
      send_byte(8'hE7, a); chk("R3 command acknowledged", {7'd0, a}, 8'd1);
      send_byte(8'(n), a); chk("R3 count acknowledged", {7'd0, a}, 8'd1);
      for (int i = 0; i < n; i++) begin
        send_byte(pat(seed, i), a);
        chk(i < 6 ? "R4 data acknowledged" : "R6 extra data acknowledged", {7'd0, a}, 8'd1);
        if (i < 6) mdl[i] = pat(seed, i);
      end
    end else begin
      send_byte(8'h00, a);
      chk("R2 silent after foreign address", {7'd0, a}, 8'd0);
    end
    bus_stop();
  endtask

  task automatic do_read();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD5, a); chk("R2 read address acknowledge", {7'd0, a}, 8'd1);
    recv_byte(1'b1, b); chk("R7 byte count", b, 8'd6);
    for (int k = 0; k < 6; k++) begin
      recv_byte(1'b1, b); chk("R7 register read-back", b, mdl[k]);
    end
    recv_byte(1'b0, b); chk("R8 read past last register", b, 8'hFF);
    bus_stop();
    for (int k = 0; k < 6; k++) chk("R4 R5 parallel register output", cfg_o[k*8 +: 8], mdl[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    logic s;
    mdl[0] = 8'h00;
    for (int k = 1; k < 6; k++) mdl[k] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(5);
    // R1 reset state
    for (int k = 0; k < 6; k++) chk("R1 reset value", cfg_o[k*8 +: 8], mdl[k]);
    chk("R1 SDA released", {7'd0, sda_oe}, 8'd0);

    for (int v = 0; v < NV; v++) begin
      do_write(VEC[v][19:12], int'(VEC[v][11:8]), VEC[v][7:0]);
      do_read();
    end

    // R9: host refuses the count byte; slave must not drive the next byte
    bus_start();
    send_byte(8'hD5, a); chk("R2 read address acknowledge", {7'd0, a}, 8'd1);
    recv_byte(1'b0, b); chk("R7 count before refusal", b, 8'd6);
    recv_byte(1'b0, b); chk("R9 SDA released after not-acknowledge", b, 8'hFF);
    chk("R9 drive enable low", {7'd0, sda_oe}, 8'd0);
    bus_stop();
    do_read();

    // R10: start after three bits of a data byte
    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h77, a); mdl[0] = 8'h77;
    clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b0, s);
    bus_start();
    send_byte(8'hD4, a); chk("R10 address after restart", {7'd0, a}, 8'd1);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h99, a); mdl[0] = 8'h99;
    chk("R10 register 1 untouched by cut byte", cfg_o[15:8], mdl[1]);
    send_byte(8'h42, a); mdl[1] = 8'h42;
    bus_stop();
    do_read();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule